// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative translation cache that sits in front of a page-table walker. It takes an 8-bit virtual address together with the identifier of the running address space. It compares the virtual page number and that identifier against every stored entry in parallel. When an entry matches, the physical address is the stored frame number placed above the untouched page offset, reported one cycle after the request. Every lookup goes to the cache first. Only a lookup that finds no entry produces a request to the page-table walker, and that request is held until the walker accepts it. The walker later supplies a new entry over a refill handshake.

Each entry carries its own address-space tag. Mappings of several processes can therefore live side by side, and a context switch does not need to empty the cache. Three maintenance inputs exist. The first clears every entry. The second clears the entries of one address space. The third clears the entry for a single page of one address space, and the page-replacement logic drives it when it evicts that page from memory. Slot choice on refill works in this order: an entry that already holds the same page, then the lowest-numbered empty entry, then the least recently used entry.

Top module: `asid_tlb`

## Requirements
- R1: After reset, no entry is valid, `rsp_valid` and `miss_valid` are low, and the first lookup misses.
- R2: A lookup with `req_valid` high reports, on the next clock edge, `rsp_valid`=1. If a valid entry matches both the page number and the address-space tag, it also reports `rsp_hit`=1 and a physical address formed from the entry's 3-bit frame number as `rsp_paddr[7:5]`.
- R3: A lookup that misses while no request is pending raises `miss_valid` on the same edge as its response, with `miss_vpn`/`miss_asid` taken from the lookup. These stay stable until a cycle with `miss_ready` high. A further miss while one is pending leaves the pending request unchanged.
- R4: `fill_ready` is high only in cycles with no lookup and no maintenance input active. A refill offered while `fill_ready` is low is not written.
- R5: A hit needs the address-space tag to match. The same page number under two tags can map to two different frames at once.
- R6: `flush_all` invalidates every entry in one cycle.
- R7: `flush_asid_en` invalidates exactly the entries whose tag equals `flush_asid`. Other entries stay valid.
- R8: `inval_en` invalidates only the entry that matches both `inval_asid` and `inval_vpn`.
- R9: A refill goes into the lowest-numbered empty entry when one exists. In that case no valid entry is evicted.
- R10: When every entry is valid, a refill replaces the entry least recently touched by a hit or a refill.
- R11: A refill whose page and tag are already present overwrites that entry's frame number and creates no second copy.
- R12: The page offset is the low 5 bits of the virtual address. The page number is the upper 3 bits, and the offset passes to `rsp_paddr[4:0]` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_asid | input | 2 | Address space of the lookup |
| req_vaddr | input | 8 | Virtual address to translate |
| rsp_valid | output | 1 | Registered result present |
| rsp_hit | output | 1 | Lookup found a matching entry |
| rsp_paddr | output | 8 | Physical address (zero on a miss) |
| miss_valid | output | 1 | Page-table request pending |
| miss_ready | input | 1 | Walker accepts the request |
| miss_asid | output | 2 | Address space of the missing page |
| miss_vpn | output | 3 | Missing page number |
| fill_valid | input | 1 | Refill entry offered |
| fill_ready | output | 1 | Refill can be written this cycle |
| fill_asid | input | 2 | Tag of the refill |
| fill_vpn | input | 3 | Page number of the refill |
| fill_pfn | input | 3 | Frame number of the refill |
| flush_all | input | 1 | Clear every entry |
| flush_asid_en | input | 1 | Clear one address space |
| flush_asid | input | 2 | Address space to clear |
| inval_en | input | 1 | Clear one page |
| inval_asid | input | 2 | Tag of the page to clear |
| inval_vpn | input | 3 | Page number to clear |

## Verification
The assertions assume that the walker never offers a refill for a page and tag that are already present, except through the overwrite path. They also assume that at most one miss is outstanding from the requester's point of view. The single-match property depends on refills arriving only through the handshake. The bench drives every input on the falling edge. It offers refills only while no lookup or maintenance input is active, except in the one case that checks `fill_ready` goes low. It drains each miss request before it issues the next missing lookup, apart from the deliberate second miss that tests holding.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int VA_W    = 8,
  parameter int OFF_W   = 5,
  parameter int ASID_W  = 2,
  parameter int PFN_W   = 3,
  parameter int ENTRIES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ASID_W-1:0]     req_asid,
  input  logic [VA_W-1:0]       req_vaddr,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic                  miss_valid,
  input  logic                  miss_ready,
  output logic [ASID_W-1:0]     miss_asid,
  output logic [VA_W-OFF_W-1:0] miss_vpn,
  input  logic                  fill_valid,
  output logic                  fill_ready,
  input  logic [ASID_W-1:0]     fill_asid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0]      fill_pfn,
  input  logic                  flush_all,
  input  logic                  flush_asid_en,
  input  logic [ASID_W-1:0]     flush_asid,
  input  logic                  inval_en,
  input  logic [ASID_W-1:0]     inval_asid,
  input  logic [VA_W-OFF_W-1:0] inval_vpn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] ent_valid;
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
  logic [IDX_W-1:0]   ent_age  [ENTRIES];

  logic [VPN_W-1:0]   look_vpn;
  logic [ENTRIES-1:0] look_vec, fill_vec, clr_vec, free_vec, old_vec;
  logic [IDX_W-1:0]   look_idx, fill_idx, touch_idx;
  logic               look_any, fill_fire, touch_en;

  assign look_vpn   = req_vaddr[VA_W-1:OFF_W];
  assign look_any   = |look_vec;
  assign fill_ready = !(req_valid || flush_all || flush_asid_en || inval_en);
  assign fill_fire  = fill_valid && fill_ready;
  assign touch_en   = fill_fire || (req_valid && look_any);
  assign touch_idx  = fill_fire ? fill_idx : look_idx;

  always_comb begin
    look_idx = '0;
    fill_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      look_vec[i] = ent_valid[i] && ent_vpn[i] == look_vpn && ent_asid[i] == req_asid;
      fill_vec[i] = ent_valid[i] && ent_vpn[i] == fill_vpn && ent_asid[i] == fill_asid;
      clr_vec[i]  = (flush_asid_en && ent_asid[i] == flush_asid) ||
                    (inval_en && ent_vpn[i] == inval_vpn && ent_asid[i] == inval_asid);
      free_vec[i] = !ent_valid[i];
      old_vec[i]  = ent_age[i] == OLDEST;
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (look_vec[i]) look_idx = IDX_W'(i);
    if (|fill_vec) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (fill_vec[i]) fill_idx = IDX_W'(i);
    end else if (|free_vec) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (free_vec[i]) fill_idx = IDX_W'(i);
    end else begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (old_vec[i]) fill_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_paddr  <= '0;
      miss_valid <= 1'b0;
      miss_asid  <= '0;
      miss_vpn   <= '0;
      ent_valid  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_vpn[i]  <= '0;
        ent_asid[i] <= '0;
        ent_pfn[i]  <= '0;
        ent_age[i]  <= IDX_W'(i);
      end
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && look_any;
      rsp_paddr <= look_any ? {ent_pfn[look_idx], req_vaddr[OFF_W-1:0]} : '0;
      if (miss_valid && miss_ready) begin
        miss_valid <= 1'b0;
      end else if (!miss_valid && req_valid && !look_any) begin
        miss_valid <= 1'b1;
        miss_asid  <= req_asid;
        miss_vpn   <= look_vpn;
      end
      if (flush_all) ent_valid <= '0;
      else ent_valid <= ent_valid & ~clr_vec;
      if (fill_fire) begin
        ent_valid[fill_idx] <= 1'b1;
        ent_vpn[fill_idx]   <= fill_vpn;
        ent_asid[fill_idx]  <= fill_asid;
        ent_pfn[fill_idx]   <= fill_pfn;
      end
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++)
          if (IDX_W'(i) == touch_idx) ent_age[i] <= '0;
          else if (ent_age[i] < ent_age[touch_idx]) ent_age[i] <= ent_age[i] + 1'b1;
    end
  end

  // R11
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(look_vec));
  // R10
  one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(old_vec));
  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) flush_all |=> !look_any);
  // R3
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !miss_ready |=> miss_valid && $stable(miss_vpn) && $stable(miss_asid));
  // R3
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_valid) |-> rsp_valid && !rsp_hit);
  // R12
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid && (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));
  // R4
  fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || inval_en || flush_asid_en || req_valid) |-> !fill_ready);
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, miss_ready = 0, fill_valid = 0;
  logic flush_all = 0, flush_asid_en = 0, inval_en = 0;
  logic [1:0] req_asid = 0, fill_asid = 0, flush_asid = 0, inval_asid = 0;
  logic [7:0] req_vaddr = 0;
  logic [2:0] fill_vpn = 0, fill_pfn = 0, inval_vpn = 0;
  logic rsp_valid, rsp_hit, miss_valid, fill_ready;
  logic [7:0] rsp_paddr;
  logic [1:0] miss_asid;
  logic [2:0] miss_vpn;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  asid_tlb dut_i (.clk, .rst_n, .req_valid, .req_asid, .req_vaddr, .rsp_valid, .rsp_hit,
    .rsp_paddr, .miss_valid, .miss_ready, .miss_asid, .miss_vpn, .fill_valid, .fill_ready,
    .fill_asid, .fill_vpn, .fill_pfn, .flush_all, .flush_asid_en, .flush_asid, .inval_en,
    .inval_asid, .inval_vpn);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [1:0] a, input logic [7:0] va, input bit hit,
                        input logic [7:0] pa, input string req);
    @(negedge clk);
    req_valid = 1; req_asid = a; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_hit == hit, req, {rsp_valid, rsp_hit}, {1'b1, hit});
    if (hit) begin
      chk(rsp_paddr == pa, req, rsp_paddr, pa);
      chk(!miss_valid, req, miss_valid, 0);
    end else begin
      chk(miss_valid && miss_vpn == va[7:5] && miss_asid == a, req, {miss_valid, miss_asid, miss_vpn},
          {1'b1, a, va[7:5]});
      miss_ready = 1;
      @(negedge clk);
      miss_ready = 0;
      chk(!miss_valid, req, miss_valid, 0);
    end
  endtask

  task automatic fill(input logic [1:0] a, input logic [2:0] v, input logic [2:0] p);
    @(negedge clk);
    fill_valid = 1; fill_asid = a; fill_vpn = v; fill_pfn = p;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_flush_all();
    @(negedge clk); flush_all = 1; @(negedge clk); flush_all = 0;
  endtask

  task automatic t_reset();
    chk(!rsp_valid && !miss_valid && fill_ready, "R1", {rsp_valid, miss_valid, fill_ready}, 3'b001);
    lookup(0, 8'h21, 0, 0, "R1");
  endtask

  task automatic t_basic();
    fill(0, 3'd1, 3'd5);
    lookup(0, 8'h21, 1, 8'hA1, "R2");
    lookup(0, 8'h3F, 1, 8'hBF, "R12");
  endtask

  task automatic t_miss_hold();
    @(negedge clk); req_valid = 1; req_asid = 0; req_vaddr = 8'h45;
    @(negedge clk); req_valid = 0;
    chk(miss_valid && miss_vpn == 3'd2 && miss_asid == 0, "R3", miss_vpn, 2);
    repeat (3) @(negedge clk);
    chk(miss_valid && miss_vpn == 3'd2, "R3", miss_vpn, 2);
    req_valid = 1; req_asid = 1; req_vaddr = 8'h60;
    @(negedge clk); req_valid = 0;
    chk(miss_valid && miss_vpn == 3'd2 && miss_asid == 0, "R3", {miss_asid, miss_vpn}, 2);
    miss_ready = 1;
    @(negedge clk); miss_ready = 0;
    chk(!miss_valid, "R3", miss_valid, 0);
  endtask

  task automatic t_asid();
    fill(1, 3'd1, 3'd2);
    lookup(0, 8'h21, 1, 8'hA1, "R5");
    lookup(1, 8'h21, 1, 8'h41, "R5");
    lookup(2, 8'h21, 0, 0, "R5");
  endtask

  task automatic t_overwrite_inval();
    fill(0, 3'd1, 3'd7);
    lookup(0, 8'h21, 1, 8'hE1, "R11");
    @(negedge clk); inval_en = 1; inval_asid = 0; inval_vpn = 3'd1;
    @(negedge clk); inval_en = 0;
    lookup(0, 8'h21, 0, 0, "R8");
    lookup(1, 8'h21, 1, 8'h41, "R8");
  endtask

  task automatic t_flush_asid();
    fill(2, 3'd6, 3'd3);
    @(negedge clk); flush_asid_en = 1; flush_asid = 1;
    @(negedge clk); flush_asid_en = 0;
    lookup(1, 8'h21, 0, 0, "R7");
    lookup(2, 8'hC0, 1, 8'h60, "R7");
  endtask

  task automatic t_ready_flush();
    @(negedge clk); req_valid = 1; req_asid = 2; req_vaddr = 8'hC0; #1;
    chk(!fill_ready, "R4", fill_ready, 0);
    @(negedge clk); req_valid = 0;
    flush_all = 1; fill_valid = 1; fill_asid = 3; fill_vpn = 3'd7; fill_pfn = 3'd1; #1;
    chk(!fill_ready, "R4", fill_ready, 0);
    @(negedge clk); flush_all = 0; fill_valid = 0;
    lookup(2, 8'hC0, 0, 0, "R6");
    lookup(3, 8'hE0, 0, 0, "R4");
  endtask

  task automatic t_lru();
    do_flush_all();
    for (int v = 0; v < 4; v++) fill(3, 3'(v), 3'(v));
    lookup(3, 8'h01, 1, 8'h01, "R10");
    fill(3, 3'd4, 3'd4);
    lookup(3, 8'h22, 0, 0, "R10");
    lookup(3, 8'h02, 1, 8'h02, "R10");
    lookup(3, 8'h43, 1, 8'h43, "R10");
    lookup(3, 8'h64, 1, 8'h64, "R10");
    lookup(3, 8'h85, 1, 8'h85, "R10");
    @(negedge clk); inval_en = 1; inval_asid = 3; inval_vpn = 3'd2;
    @(negedge clk); inval_en = 0;
    fill(3, 3'd5, 3'd5);
    lookup(3, 8'h06, 1, 8'h06, "R9");
    lookup(3, 8'hA7, 1, 8'hA7, "R9");
    lookup(3, 8'h68, 1, 8'h68, "R9");
    lookup(3, 8'h49, 0, 0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_miss_hold();
    t_asid();
    t_overwrite_inval();
    t_flush_asid();
    t_ready_flush();
    t_lru();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule